// File: doc/BRIEF.md
# Parallel Register Bus Slave with Auto-Increment Bursts

This block is the device side of a parallel microprocessor bus that uses separate active-low read and write strobes. It gives access to an internal file of byte-wide registers. A host first presents a 7-bit location on the address pins and pulses the address-latch input. It then runs one or more strobe cycles while chip select is held low. Every bus pin passes through a two-stage synchronizer and is examined in the system clock domain, so the bus may be fully asynchronous to `clk`.

If the latch input stays low after the first access, each completed strobe advances the internal address by one. This lets a host sweep a contiguous range of registers without sending the address again. A rising latch input ends the burst. While the latch input is high, the internal address follows the address pins and does not advance. The data bus is split at the boundary into an input, an output and an output-enable for the pad. The enable is asserted only while a read is in progress.

Top module: `pbus_regif`

## Requirements
- R1: After a synchronous reset, `data_oe` is 0 and the internal address is 0.
- R2: Every bus input is sampled through two flip-flops, and edges are detected on the synchronized copies. A pin change is therefore acted on at the third rising clock edge after it is applied.
- R3: On a falling edge of `ale`, the value on `addr` is taken as the internal address.
- R4: A write happens on a rising edge of `wr_n` while `cs_n` is low and `rd_n` is high. The byte on `data_i` is stored at the internal address.
- R5: A falling edge of `rd_n` while `cs_n` is low and `wr_n` is high loads `data_o` with the byte at the internal address. `data_oe` is 1 exactly while synchronized `cs_n` and `rd_n` are both low, and 0 otherwise.
- R6: While `ale` stays low, each completed write (rising `wr_n`) or read (rising `rd_n`) with `cs_n` low advances the internal address by one.
- R7: The address advance wraps from 127 to 0.
- R8: A strobe cycle while `cs_n` is high writes nothing, drives nothing and does not advance the address.
- R9: While `ale` is high, the internal address tracks `addr` and strobes do not advance it. A rising `ale` therefore ends a burst, and accesses made with `ale` held high all use the pin address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch strobe; falling edge captures `addr` |
| wr_n | input | 1 | Write strobe, active low; rising edge commits the write |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 7 | Register location |
| data_i | input | 8 | Write data from the bus pad |
| data_o | output | 8 | Read data to the bus pad |
| data_oe | output | 1 | Pad drive enable for `data_o` |

## Verification
On every cycle, the checker verifies the following from the synchronized pin copies:
- The address follows the pins while the latch input is high, and is latched on its falling edge.
- The address steps by one, wrapping at the top, after each selected strobe completes in a burst.
- The address stays put when chip select is high.
- The output enable is never high without a selected read.

Other behaviour is visible only over whole bus transactions, so only the bench's scenarios can show it:
- That written bytes land at the right locations and are read back later.
- That a deselected write leaves memory untouched.
- That the three-edge pin-to-action latency is exact.

The bench's reference model follows the delayed pin history, and the directed scenarios read back the contents.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int PB_ADDR_W = 7;
  localparam int PB_DATA_W = 8;
  localparam int PB_SYNC_STAGES = 2;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pbus_addr_ctrl.sv
module pbus_addr_ctrl #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_s,
  input  logic          ale_s,
  input  logic          wr_n_s,
  input  logic          rd_n_s,
  input  logic [AW-1:0] addr_s,
  output logic [AW-1:0] cur_addr,
  output logic          wr_en,
  output logic          rd_en
);
  logic ale_q, wr_n_q, rd_n_q;
  logic ale_fall, wr_rise, rd_fall, rd_rise, step;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q  <= 1'b0;
      wr_n_q <= 1'b1;
      rd_n_q <= 1'b1;
    end else begin
      ale_q  <= ale_s;
      wr_n_q <= wr_n_s;
      rd_n_q <= rd_n_s;
    end
  end

  assign ale_fall = ale_q & ~ale_s;
  assign wr_rise  = ~wr_n_q & wr_n_s;
  assign rd_fall  = rd_n_q & ~rd_n_s;
  assign rd_rise  = ~rd_n_q & rd_n_s;

  assign wr_en = wr_rise & ~cs_n_s & rd_n_s;
  assign rd_en = rd_fall & ~cs_n_s & wr_n_s;
  assign step  = (wr_en | (rd_rise & ~cs_n_s & wr_n_s)) & ~ale_s;

  always_ff @(posedge clk) begin
    if (rst)           cur_addr <= '0;
    else if (ale_s)    cur_addr <= addr_s;
    else if (ale_fall) cur_addr <= addr_s;
    else if (step)     cur_addr <= cur_addr + AW'(1);
  end
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/pbus_regif.sv
module pbus_regif
  import pbus_pkg::*;
#(
  parameter int AW = PB_ADDR_W,
  parameter int DW = PB_DATA_W,
  parameter int SYNC_STAGES = PB_SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          ale,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe
);
  localparam int SW = 4 + AW + DW;
  localparam logic [SW-1:0] IDLE = {1'b1, 1'b0, 1'b1, 1'b1, {(AW+DW){1'b0}}};

  logic [SW-1:0] pins_raw, pins_s;
  logic          cs_n_s, ale_s, wr_n_s, rd_n_s;
  logic [AW-1:0] addr_s, cur_addr;
  logic [DW-1:0] data_s;
  logic          wr_en, rd_en;

  assign pins_raw = {cs_n, ale, wr_n, rd_n, addr, data_i};

  pbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  assign {cs_n_s, ale_s, wr_n_s, rd_n_s, addr_s, data_s} = pins_s;

  pbus_addr_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst),
    .cs_n_s(cs_n_s), .ale_s(ale_s), .wr_n_s(wr_n_s), .rd_n_s(rd_n_s),
    .addr_s(addr_s), .cur_addr(cur_addr), .wr_en(wr_en), .rd_en(rd_en)
  );

  pbus_regfile #(.AW(AW), .DW(DW)) u_rf (
    .clk(clk), .addr(cur_addr), .we(wr_en), .wdata(data_s),
    .re(rd_en), .rdata(data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) data_oe <= 1'b0;
    else     data_oe <= ~cs_n_s & ~rd_n_s;
  end
endmodule

// File: rtl/pbus_regif_sva.sv
module pbus_regif_sva #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n_s,
  input logic          ale_s,
  input logic          wr_n_s,
  input logic          rd_n_s,
  input logic [AW-1:0] addr_s,
  input logic [AW-1:0] cur_addr,
  input logic          data_oe
);
  logic pa, pw, pr;
  logic done;

  always_ff @(posedge clk) begin
    if (rst) begin
      pa <= 1'b0; pw <= 1'b1; pr <= 1'b1;
    end else begin
      pa <= ale_s; pw <= wr_n_s; pr <= rd_n_s;
    end
  end

  assign done = !cs_n_s && !ale_s && !pa &&
                ((!pw && wr_n_s && rd_n_s) || (!pr && rd_n_s && wr_n_s));

  p_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (pa && !ale_s) |=> cur_addr == $past(addr_s));

  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> cur_addr == AW'($past(cur_addr) + AW'(1)));

  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (done && &cur_addr) |=> cur_addr == '0);

  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (cs_n_s && !ale_s && !pa) |=> $stable(cur_addr));

  p_follow_r9: assert property (@(posedge clk) disable iff (rst)
    ale_s |=> cur_addr == $past(addr_s));

  p_oe_r5: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> $past(!cs_n_s && !rd_n_s));
endmodule

bind pbus_regif pbus_regif_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .ale_s(ale_s), .wr_n_s(wr_n_s),
  .rd_n_s(rd_n_s), .addr_s(addr_s), .cur_addr(cur_addr), .data_oe(data_oe)
);

// File: tb/pbus_regif_tb.sv
module pbus_regif_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, cs_n = 1'b1, ale = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [6:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic doe;
  int errors = 0, checks = 0;
  bit done_flag = 0;

  pbus_regif u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ale(ale), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .data_i(din), .data_o(dout), .data_oe(doe)
  );

  typedef struct { bit cs_n; bit ale; bit wr_n; bit rd_n; int a; int d; } pins_t;
  pins_t h[$];
  int mem_m[128];
  int addr_m = 0, dout_m = -1;
  bit oe_m = 0;

  // Reference model: actions use pin values from two and three edges back (R2)
  always @(posedge clk) begin
    pins_t now, c, p, idle;
    bit wr_ok, rd_go, rd_end;
    now = '{cs_n, ale, wr_n, rd_n, int'(addr), int'(din)};
    idle = '{1'b1, 1'b0, 1'b1, 1'b1, 0, 0};
    if (rst) begin
      h.delete();
      for (int i = 0; i < 4; i++) h.push_back(idle);
      for (int i = 0; i < 128; i++) mem_m[i] = -1;
      addr_m = 0; oe_m = 0; dout_m = -1;
    end else begin
      h.push_front(now);
      c = h[2]; p = h[3];
      void'(h.pop_back());
      wr_ok  = !p.wr_n && c.wr_n && !c.cs_n && c.rd_n;
      rd_go  = p.rd_n && !c.rd_n && !c.cs_n && c.wr_n;
      rd_end = !p.rd_n && c.rd_n && !c.cs_n && c.wr_n;
      if (wr_ok) mem_m[addr_m] = c.d;
      if (rd_go) dout_m = mem_m[addr_m];
      if (c.ale) addr_m = c.a;
      else if (p.ale) addr_m = c.a;
      else if (wr_ok || rd_end) addr_m = (addr_m + 1) % 128;
      oe_m = !c.cs_n && !c.rd_n;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      checks++;
      if (doe !== oe_m) begin
        errors++;
        $display("FAIL R5/R2 model data_oe actual=%0b expected=%0b t=%0t", doe, oe_m, $time);
      end
      if (oe_m && dout_m >= 0) begin
        checks++;
        if (dout !== dout_m[7:0]) begin
          errors++;
          $display("FAIL R5/R2 model data_o actual=%0h expected=%0h t=%0t", dout, dout_m[7:0], $time);
        end
      end
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch(int a);
    addr = 7'(a); ale = 1'b1; tick(3); ale = 1'b0; tick(3);
  endtask

  task automatic wr(int d, bit sel = 1);
    cs_n = !sel; din = 8'(d); wr_n = 1'b0; tick(3);
    wr_n = 1'b1; tick(3); cs_n = 1'b1; tick(1);
  endtask

  task automatic rd(output int v);
    cs_n = 1'b0; rd_n = 1'b0; tick(5);
    v = (doe === 1'b1) ? int'(dout) : -1;
    rd_n = 1'b1; tick(3); cs_n = 1'b1; tick(1);
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    tick(5); rst = 1'b0; tick(1);
    chk("R1 data_oe after reset", doe, 0);

    // R3 R4 R5 single access
    latch(5); wr(8'hA5);
    latch(5); rd(v); chk("R4 single write readback", v, 8'hA5);
    tick(2); chk("R5 oe released", doe, 0);

    // R6 burst write then burst read
    latch(20);
    wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
    latch(20);
    rd(v); chk("R6 burst[0]", v, 8'h11);
    rd(v); chk("R6 burst[1]", v, 8'h22);
    rd(v); chk("R6 burst[2]", v, 8'h33);
    rd(v); chk("R6 burst[3]", v, 8'h44);

    // R7 wrap
    latch(126); wr(8'h71); wr(8'h72); wr(8'h73);
    latch(0);   rd(v); chk("R7 wrap to 0", v, 8'h73);
    latch(127); rd(v); chk("R7 location 127", v, 8'h72);

    // R8 deselected strobe ignored
    latch(41); wr(8'h99);
    latch(40); wr(8'h01); wr(8'hEE, 0); wr(8'h02);
    latch(41); rd(v); chk("R8 no advance on cs high", v, 8'h02);
    latch(40); rd(v); chk("R8 no write on cs high", v, 8'h01);
    rd_n = 1'b0; tick(5); chk("R8 read with cs high no drive", doe, 0);
    rd_n = 1'b1; tick(3);

    // R9 rising ale ends burst
    latch(60); wr(8'h10);
    addr = 7'd70; ale = 1'b1; tick(3);
    wr(8'h20); wr(8'h21);
    ale = 1'b0; tick(3);
    latch(70); rd(v); chk("R9 ale high fixed address", v, 8'h21);
    latch(60); rd(v); chk("R9 burst start intact", v, 8'h10);
    latch(61); wr(8'h5A); latch(61); rd(v); chk("R3 relatch", v, 8'h5A);

    tick(5);
    finish_run();
  end
endmodule